// File: doc/BRIEF.md
# Priority Read Scheduler with Lookahead

This block drives the read side of a multi-queue FIFO. Each cycle it looks at every queue's empty and almost-empty flags and picks the queue to read next. Priority is fixed by index, and queue 0 ranks highest. A queue that is close to running dry is passed over in favour of a lower-priority queue that still has room to drain. This lets the switch happen early, while the words already in flight use up the last entries of the old queue. Read enable stays high in every cycle that any queue holds data, so the read bus does not idle at queue switches.

The block registers its read address, address-lock strobe and read enable. The FIFO returns data a fixed number of cycles after a read, three by default. The block delays a valid flag and a queue tag through a matching pipeline, so the consumer can see which queue each returned word came from. The lock strobe is issued only when the chosen queue differs from the one last locked, so a queue that goes idle and resumes is not locked again.

Top module: `prio_rd_sched`

## Requirements
- R1: While `rstN` is low and at the first sample after it rises, `rdEn`, `rdAddrLock`, `dataValid`, `rdAddr` and `dataTag` are all 0.
- R2: `rdEn` is 1 one cycle after any bit of `qEmpty` is 0. When every bit of `qEmpty` is 1, the next cycle has `rdEn` = 0 and `rdAddrLock` = 0. A `qEmpty` bit at 1 means that queue is empty.
- R3: When at least one queue has its `qEmpty` bit at 0 and its `qAlmostEmpty` bit at 0, `rdAddr` one cycle later is the lowest such index. A `qAlmostEmpty` bit at 1 means that queue is nearly drained.
- R4: When every non-empty queue has its `qAlmostEmpty` bit at 1, `rdAddr` one cycle later is the lowest index whose `qEmpty` bit is 0.
- R5: `rdAddrLock` is 1 for one cycle, together with the new `rdAddr`, only when the selected queue differs from the last locked queue, or when it is the first selection after reset. `rdAddr` changes only in a cycle with `rdAddrLock` = 1, and holds its value while idle.
- R6: `dataValid` equals `rdEn` delayed by LAT cycles (LAT = 3 by default), and `rdAddrLock` is never 1 without `rdEn`.
- R7: When `dataValid` is 1, `dataTag` equals the `rdAddr` presented LAT cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rstN | input | 1 | Synchronous reset, active low |
| qEmpty | input | NQ | Per-queue empty flag, 1 = empty |
| qAlmostEmpty | input | NQ | Per-queue almost-empty flag, 1 = nearly drained |
| rdAddr | output | $clog2(NQ) | Queue address presented to the FIFO |
| rdAddrLock | output | 1 | Latches `rdAddr` as the new read queue |
| rdEn | output | 1 | Read enable |
| dataValid | output | 1 | Returned read data is valid this cycle |
| dataTag | output | $clog2(NQ) | Queue index of the returned word |

## Verification
Flags driven in one cycle appear on `rdEn`, `rdAddrLock` and `rdAddr` after exactly one clock edge. The same flags appear on `dataValid` and `dataTag` after 1 + LAT edges. The bench keeps a short history of its own expected values, indexed by that lag. It compares each output against the history entry from the matching earlier cycle, sampling on the falling edge. The stimulus includes idle stretches, a resume on the same queue, almost-empty skips and fallbacks, and a drain at the end, so every entry still in the pipeline is checked.

// File: rtl/prio_rd_pkg.sv
package prio_rd_pkg;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic issue;  // perform a read this cycle
    logic lock;   // latch a new queue address
  } rd_strb_t;

endpackage

// File: rtl/prio_rd_ctrl.sv
module prio_rd_ctrl #(
  parameter int NQ = 8,
  parameter int QW = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NQ-1:0]           qEmpty,
  input  logic [NQ-1:0]           qAlmostEmpty,
  output prio_rd_pkg::rd_strb_t   strb,
  output logic [QW-1:0]           selQ
);

  logic [QW-1:0] lockedQ;
  logic          lockedValid;
  logic          anyQ;
  logic          firmHit;
  logic [QW-1:0] firmQ;
  logic [QW-1:0] anyIdx;

  // scan from the lowest priority upward so the lowest index wins
  always_comb begin
    anyQ    = 1'b0;
    firmHit = 1'b0;
    firmQ   = '0;
    anyIdx  = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (!qEmpty[i]) begin
        anyQ   = 1'b1;
        anyIdx = QW'(i);
        if (!qAlmostEmpty[i]) begin
          firmHit = 1'b1;
          firmQ   = QW'(i);
        end
      end
    end
    selQ       = firmHit ? firmQ : anyIdx;
    strb.issue = anyQ;
    strb.lock  = anyQ && (!lockedValid || (lockedQ != selQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ     <= '0;
      lockedValid <= 1'b0;
    end else if (strb.lock) begin
      lockedQ     <= selQ;
      lockedValid <= 1'b1;
    end
  end

  // R3
  pick_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> !qEmpty[selQ]);

  // R2
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&qEmpty) |-> (!strb.issue && !strb.lock));

  // R4
  fallback_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && qAlmostEmpty[selQ]) |-> ((~qEmpty & ~qAlmostEmpty) == '0));

endmodule

// File: rtl/prio_rd_dpath.sv
module prio_rd_dpath #(
  parameter int QW  = 3,
  parameter int LAT = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  prio_rd_pkg::rd_strb_t strb,
  input  logic [QW-1:0]         selQ,
  output logic [QW-1:0]         rdAddr,
  output logic                  rdAddrLock,
  output logic                  rdEn,
  output logic                  dataValid,
  output logic [QW-1:0]         dataTag
);

  localparam int LastStage = LAT - 1;

  logic [LAT-1:0]         pipeV;
  logic [LAT-1:0][QW-1:0] pipeT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr     <= '0;
      rdAddrLock <= 1'b0;
      rdEn       <= 1'b0;
    end else begin
      rdEn       <= strb.issue;
      rdAddrLock <= strb.lock;
      if (strb.lock) rdAddr <= selQ;
    end
  end

  // return pipeline that matches the FIFO read latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeV <= '0;
      pipeT <= '0;
    end else begin
      for (int k = LastStage; k > 0; k--) begin
        pipeV[k] <= pipeV[k-1];
        pipeT[k] <= pipeT[k-1];
      end
      pipeV[0] <= rdEn;
      pipeT[0] <= rdAddr;
    end
  end

  assign dataValid = pipeV[LastStage];
  assign dataTag   = pipeT[LastStage];

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr != $past(rdAddr)) |-> rdAddrLock);

  // R6
  lock_with_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAddrLock |-> rdEn);

  generate
    if (LAT == 3) begin : g_lag3
      // R6
      valid_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
        dataValid == $past(rdEn, 3));
    end else if (LAT == 1) begin : g_lag1
      // R6
      valid_lag1_chk: assert property (@(posedge clk) disable iff (!rstN)
        dataValid == $past(rdEn));
    end
  endgenerate

endmodule

// File: rtl/prio_rd_sched.sv
module prio_rd_sched #(
  parameter int NQ  = 8,
  parameter int LAT = 3,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NQ-1:0] qEmpty,
  input  logic [NQ-1:0] qAlmostEmpty,
  output logic [QW-1:0] rdAddr,
  output logic          rdAddrLock,
  output logic          rdEn,
  output logic          dataValid,
  output logic [QW-1:0] dataTag
);

  prio_rd_pkg::rd_strb_t strb;
  logic [QW-1:0]         selQ;

  prio_rd_ctrl #(.NQ(NQ), .QW(QW)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .qEmpty       (qEmpty),
    .qAlmostEmpty (qAlmostEmpty),
    .strb         (strb),
    .selQ         (selQ)
  );

  prio_rd_dpath #(.QW(QW), .LAT(LAT)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .selQ       (selQ),
    .rdAddr     (rdAddr),
    .rdAddrLock (rdAddrLock),
    .rdEn       (rdEn),
    .dataValid  (dataValid),
    .dataTag    (dataTag)
  );

endmodule

// File: tb/prio_rd_sched_tb.sv
module prio_rd_sched_tb_top;

  localparam int NQ  = 8;
  localparam int LAT = 3;
  localparam int QW  = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NQ-1:0] qEmpty = '1;
  logic [NQ-1:0] qAlmostEmpty = '1;
  logic [QW-1:0] rdAddr;
  logic          rdAddrLock;
  logic          rdEn;
  logic          dataValid;
  logic [QW-1:0] dataTag;

  prio_rd_sched #(.NQ(NQ), .LAT(LAT)) dut_i (
    .clk (clk), .rstN (rstN), .qEmpty (qEmpty), .qAlmostEmpty (qAlmostEmpty),
    .rdAddr (rdAddr), .rdAddrLock (rdAddrLock), .rdEn (rdEn),
    .dataValid (dataValid), .dataTag (dataTag)
  );

  always #2 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  // expected-value history: index 0 = previous step
  bit            hV [0:LAT];
  logic [QW-1:0] hT [0:LAT];
  bit            hL;
  logic [QW-1:0] expAddr;
  string         addrReq;
  logic [QW-1:0] mLocked;
  bit            mLockedValid;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [QW:0] pickQ(input logic [NQ-1:0] e, input logic [NQ-1:0] a);
    // returns {firmFound, index}
    for (int i = 0; i < NQ; i++)
      if (!e[i] && !a[i]) return {1'b1, QW'(i)};
    for (int i = 0; i < NQ; i++)
      if (!e[i]) return {1'b0, QW'(i)};
    return '0;
  endfunction

  task automatic step(input logic [NQ-1:0] e, input logic [NQ-1:0] a);
    logic [QW:0] p;
    bit issue;
    bit lock;
    // outputs due from the previous step's flags
    chk(rdEn == hV[0], "R2 rdEn", int'(rdEn), int'(hV[0]));
    chk(rdAddrLock == hL, "R5 lock", int'(rdAddrLock), int'(hL));
    chk(rdAddr == expAddr, addrReq, int'(rdAddr), int'(expAddr));
    chk(dataValid == hV[LAT], "R6 dataValid", int'(dataValid), int'(hV[LAT]));
    if (hV[LAT]) chk(dataTag == hT[LAT], "R7 dataTag", int'(dataTag), int'(hT[LAT]));
    for (int k = LAT; k > 0; k--) begin
      hV[k] = hV[k-1];
      hT[k] = hT[k-1];
    end
    p = pickQ(e, a);
    issue = (e != '1);
    lock = issue && (!mLockedValid || (mLocked != p[QW-1:0]));
    if (lock) begin
      mLocked = p[QW-1:0];
      mLockedValid = 1'b1;
      expAddr = p[QW-1:0];
    end
    if (issue) addrReq = p[QW] ? "R3 rdAddr" : "R4 rdAddr";
    hV[0] = issue;
    hT[0] = expAddr;
    hL = lock;
    qEmpty = e;
    qAlmostEmpty = a;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k <= LAT; k++) begin
      hV[k] = 1'b0;
      hT[k] = '0;
    end
    hL = 1'b0;
    expAddr = '0;
    addrReq = "R5 rdAddr hold";
    mLocked = '0;
    mLockedValid = 1'b0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rdEn == 1'b0, "R1 rdEn", int'(rdEn), 0);
    chk(rdAddrLock == 1'b0, "R1 lock", int'(rdAddrLock), 0);
    chk(dataValid == 1'b0, "R1 dataValid", int'(dataValid), 0);
    chk(rdAddr == '0, "R1 rdAddr", int'(rdAddr), 0);
    chk(dataTag == '0, "R1 dataTag", int'(dataTag), 0);
    rstN = 1'b1;
    // R2 idle: no read, no lock
    step('1, '1);
    step('1, '1);
    // first selection after reset locks, only queue 7 present
    step(~8'h80, 8'h00);
    step(~8'h80, 8'h00);
    // R3: queue 0 nearly drained, queue 3 preferred
    step(~8'h09, 8'h01);
    // R4: both nearly drained, fall back to queue 0
    step(~8'h09, 8'h09);
    step(~8'h09, 8'h09);
    // idle, then resume on the same queue: R5 no relock
    step('1, '1);
    step('1, '1);
    step(~8'h01, 8'h01);
    // continuous reads across priority switches
    step(~8'hF0, 8'h00);
    step(~8'hF1, 8'h00);
    step(~8'hF0, 8'h10);
    step(~8'h80, 8'h80);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [NQ-1:0] e;
      logic [NQ-1:0] a;
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) e = '1;
      else if (r < 4) e = ~(NQ'(1) << $urandom_range(0, NQ - 1));
      else e = NQ'($urandom) | NQ'($urandom);
      a = NQ'($urandom) & NQ'($urandom_range(0, 1) ? $urandom : 32'hFFFF_FFFF);
      step(e, a);
      if ($urandom_range(0, 3) == 0) step(e, a);
    end
    // drain the return pipeline
    for (int n = 0; n <= LAT + 1; n++) step('1, '1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule